// File: doc/BRIEF.md
# Single-Operand Bit-Count and Magnitude Unit

This unit decodes and executes one class of single-source integer instructions for a 64-bit core. Each instruction computes one of five results from a source value. The five results are the count of zeros above the highest set bit, the count of copies of the sign bit below the sign position, the count of zeros below the lowest set bit, the number of set bits, and the absolute value. The register file supplies the source value. The unit returns the destination index, the result and a write-enable one cycle later.

A single instruction bit picks full 64-bit or narrow 32-bit operation. A narrow result is always zero-extended into the 64-bit destination. Three of the operations belong to an optional extension. They are accepted only while the extension-enable input is high. The unit raises an undefined flag for any encoding it does not accept and does not write the destination. Handling the fault is left to the surrounding pipeline.

Top module: `bmu_unit`

## Requirements
- R1: An instruction belongs to this class only when bits 30:16 equal 15'b101101011000000. Any other value raises `out_undef` with `out_we` low.
- R2: The opcode sits in bits 15:10 and is decoded as follows:
  - 6'b000100: leading-zero count.
  - 6'b000101: leading-sign count.
  - 6'b000110: trailing-zero count.
  - 6'b000111: set-bit count.
  - 6'b001000: absolute value.

  Any other opcode raises `out_undef`, holds `out_we` low and gives a zero result.
- R3: Bit 31 = 1 selects 64-bit operation. Bit 31 = 0 uses only source bits 31:0, and the 32-bit result is zero-extended.
- R4: The leading-zero count gives the number of zeros above the highest set bit within the selected width. An all-zero operand gives the width (32 or 64).
- R5: The leading-sign count gives the number of bits directly below the sign bit that equal it, not counting the sign bit. Both 0 and all-ones give width minus one.
- R6: The trailing-zero count gives the number of zeros below the lowest set bit. An all-zero operand gives the width.
- R7: The set-bit count gives the number of ones within the selected width.
- R8: The absolute value negates negative operands at the selected width. The most negative value maps to itself, and no overflow is reported.
- R9: Opcodes 000110, 000111 and 001000 are accepted only while `feat_en` is 1. Otherwise they raise `out_undef` with `out_we` low.
- R10: The outputs are registered and follow a valid input by exactly one cycle, with `out_valid` high and `out_rd` equal to instruction bits 4:0. A cycle with `in_valid` low yields `out_valid`, `out_we`, `out_undef` and `out_result` all zero.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operand are present |
| feat_en | input | 1 | Enables the extension operations |
| instr | input | 32 | Instruction word |
| src | input | 64 | Source register value |
| out_valid | output | 1 | Registered result is present |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Result value |
| out_we | output | 1 | Write the result to the destination |
| out_undef | output | 1 | Encoding not accepted |

## Verification
The unit holds no state beyond its single output register. Any decode or datapath fault shows on the ports in the cycle right after the faulty instruction is presented. The bench therefore compares every output field against a behavioural model on every clock. A width-masking fault appears as nonzero upper result bits, or as a wrong count for operands with bits set above position 31. A gating fault shows as `out_we` high where `out_undef` was expected. Boundary operands are applied at both widths: zero, all-ones, the most negative value and single set bits.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    typedef enum logic [2:0] {
        OP_LZC  = 3'd0,
        OP_LSC  = 3'd1,
        OP_TZC  = 3'd2,
        OP_POP  = 3'd3,
        OP_MAG  = 3'd4,
        OP_NONE = 3'd7
    } bmu_op_e;

    localparam logic [14:0] CLASS_BITS = 15'b101101011000000;
    localparam logic [5:0]  OPC_LZC    = 6'b000100;
    localparam logic [5:0]  OPC_LSC    = 6'b000101;
    localparam logic [5:0]  OPC_TZC    = 6'b000110;
    localparam logic [5:0]  OPC_POP    = 6'b000111;
    localparam logic [5:0]  OPC_MAG    = 6'b001000;
endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        feat_en,
    output bmu_op_e     op,
    output logic        wide,
    output logic        legal,
    output logic [4:0]  rd
);
    logic ext_op;
    logic unused_rn;

    assign unused_rn = ^instr[9:5];

    always_comb begin
        wide = instr[31];
        rd   = instr[4:0];
        unique case (instr[15:10])
            OPC_LZC: op = OP_LZC;
            OPC_LSC: op = OP_LSC;
            OPC_TZC: op = OP_TZC;
            OPC_POP: op = OP_POP;
            OPC_MAG: op = OP_MAG;
            default: op = OP_NONE;
        endcase
        ext_op = (op == OP_TZC) || (op == OP_POP) || (op == OP_MAG);
        legal  = (instr[30:16] == CLASS_BITS) && (op != OP_NONE) && (!ext_op || feat_en);
    end
endmodule

// File: rtl/bmu_lead_zero.sv
module bmu_lead_zero #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    input  logic          wide,
    output logic [CW-1:0] lz
);
    localparam int HALF = W / 2;

    logic found;
    int   top;

    always_comb begin
        top   = wide ? (W - 1) : (HALF - 1);
        lz    = wide ? CW'(W) : CW'(HALF);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && (wide || i < HALF) && val[i]) begin
                lz    = CW'(top - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bmu_trail_pop.sv
module bmu_trail_pop #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    input  logic          wide,
    output logic [CW-1:0] tz,
    output logic [CW-1:0] pc
);
    localparam int HALF = W / 2;

    logic found;

    always_comb begin
        tz    = wide ? CW'(W) : CW'(HALF);
        pc    = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (wide || i < HALF) begin
                if (!found && val[i]) begin
                    tz    = CW'(i);
                    found = 1'b1;
                end
                pc = pc + CW'(val[i]);
            end
        end
    end
endmodule

// File: rtl/bmu_unit.sv
module bmu_unit
    import bmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            feat_en,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src,
    output logic            out_valid,
    output logic [4:0]      out_rd,
    output logic [XLEN-1:0] out_result,
    output logic            out_we,
    output logic            out_undef
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN) + 1;

    typedef struct packed {
        logic            vld;
        logic            we;
        logic            undef;
        logic [4:0]      rd;
        logic [XLEN-1:0] res;
    } out_t;

    out_t            out_d, out_q;
    bmu_op_e         op;
    logic            wide, legal;
    logic [4:0]      rd;
    logic            sign;
    logic [XLEN-1:0] lz_in;
    logic [CW-1:0]   lz, tz, pc;
    logic [HALF-1:0] lo, lo_mag;
    logic [XLEN-1:0] mag, res;

    bmu_decode u_dec (
        .instr   (instr),
        .feat_en (feat_en),
        .op      (op),
        .wide    (wide),
        .legal   (legal),
        .rd      (rd)
    );

    // Sign-run counting reuses the zero counter on src XOR sign.
    assign sign  = wide ? src[XLEN-1] : src[HALF-1];
    assign lz_in = (op == OP_LSC) ? (src ^ {XLEN{sign}}) : src;

    bmu_lead_zero #(.W(XLEN), .CW(CW)) u_lz (
        .val  (lz_in),
        .wide (wide),
        .lz   (lz)
    );

    bmu_trail_pop #(.W(XLEN), .CW(CW)) u_tp (
        .val  (src),
        .wide (wide),
        .tz   (tz),
        .pc   (pc)
    );

    always_comb begin
        lo     = src[HALF-1:0];
        lo_mag = lo[HALF-1] ? ((~lo) + HALF'(1)) : lo;
        if (wide)
            mag = src[XLEN-1] ? ((~src) + XLEN'(1)) : src;
        else
            mag = {{HALF{1'b0}}, lo_mag};

        unique case (op)
            OP_LZC:  res = {{(XLEN-CW){1'b0}}, lz};
            OP_LSC:  res = {{(XLEN-CW){1'b0}}, lz - CW'(1)};
            OP_TZC:  res = {{(XLEN-CW){1'b0}}, tz};
            OP_POP:  res = {{(XLEN-CW){1'b0}}, pc};
            OP_MAG:  res = mag;
            default: res = '0;
        endcase

        out_d = '0;
        if (in_valid) begin
            out_d.vld   = 1'b1;
            out_d.rd    = rd;
            out_d.we    = legal;
            out_d.undef = !legal;
            out_d.res   = legal ? res : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid  = out_q.vld;
    assign out_rd     = out_q.rd;
    assign out_result = out_q.res;
    assign out_we     = out_q.we;
    assign out_undef  = out_q.undef;

    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_we && !out_undef));

    p_undef_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> !out_we);

    p_narrow_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[31]) |=> (out_result[XLEN-1:HALF] == '0));

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !feat_en &&
         (instr[15:10] == OPC_TZC || instr[15:10] == OPC_POP || instr[15:10] == OPC_MAG))
        |=> (out_undef && !out_we));

    p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[30:16] != CLASS_BITS) |=> out_undef);
endmodule

// File: tb/bmu_unit_tb.sv
module bmu_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        feat_en;
    logic [31:0] instr;
    logic [63:0] src;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic [63:0] out_result;
    logic        out_we;
    logic        out_undef;

    int n_vec  = 0;
    int n_fail = 0;

    localparam logic [14:0] FIXED = 15'b101101011000000;

    always #5 clk = ~clk;

    bmu_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .feat_en    (feat_en),
        .instr      (instr),
        .src        (src),
        .out_valid  (out_valid),
        .out_rd     (out_rd),
        .out_result (out_result),
        .out_we     (out_we),
        .out_undef  (out_undef)
    );

    function automatic bit [31:0] mk(bit sf, bit [5:0] opc, bit [4:0] rn, bit [4:0] rd);
        return {sf, FIXED, opc, rn, rd};
    endfunction

    // Behavioural reference: returns {valid, we, undef, rd, result}
    function automatic bit [71:0] model(bit v, bit [31:0] ins, bit [63:0] s, bit fe);
        int w, n;
        bit [63:0] x, r;
        bit ok, ext;
        if (!v) return '0;
        w   = ins[31] ? 64 : 32;
        x   = ins[31] ? s : {32'h0, s[31:0]};
        ok  = (ins[30:16] == FIXED);
        ext = 1'b0;
        r   = '0;
        n   = 0;
        case (ins[15:10])
            6'd4: begin while (n < w && !x[w-1-n]) n++; r = 64'(n); end
            6'd5: begin while (n < w-1 && x[w-2-n] == x[w-1]) n++; r = 64'(n); end
            6'd6: begin ext = 1; while (n < w && !x[n]) n++; r = 64'(n); end
            6'd7: begin ext = 1; for (int k = 0; k < w; k++) n += int'(x[k]); r = 64'(n); end
            6'd8: begin
                ext = 1;
                r = x[w-1] ? (~x + 64'd1) : x;
                if (w == 32) r = r & 64'hFFFF_FFFF;
            end
            default: ok = 1'b0;
        endcase
        if (ext && !fe) ok = 1'b0;
        if (!ok) r = '0;
        return {1'b1, ok, !ok, ins[4:0], r};
    endfunction

    function automatic string tag_of(bit v, bit [31:0] ins, bit fe);
        if (!v) return "R10";
        if (ins[30:16] != FIXED) return "R1";
        case (ins[15:10])
            6'd4: return ins[31] ? "R4" : "R4/R3";
            6'd5: return ins[31] ? "R5" : "R5/R3";
            6'd6: return fe ? "R6" : "R9";
            6'd7: return fe ? "R7" : "R9";
            6'd8: return fe ? "R8" : "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic apply(bit v, bit [31:0] ins, bit [63:0] s, bit fe);
        bit [71:0] exp_v, act;
        in_valid = v;
        instr    = ins;
        src      = s;
        feat_en  = fe;
        exp_v    = model(v, ins, s, fe);
        @(negedge clk);
        act = {out_valid, out_we, out_undef, out_rd, out_result};
        n_vec++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s instr=%h src=%h actual=%h expected=%h",
                     tag_of(v, ins, fe), ins, s, act, exp_v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        bit [5:0]  ops [5] = '{6'd4, 6'd5, 6'd6, 6'd7, 6'd8};
        bit [63:0] pats[10] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                               64'h0000_0000_8000_0000, 64'h1, 64'h0000_0001_0000_0000,
                               64'h0000_0000_0001_0000, 64'h4000_0000_0000_0000,
                               64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF};
        rst_n = 1'b0; in_valid = 1'b0; feat_en = 1'b1; instr = '0; src = '0;
        repeat (2) @(negedge clk);
        // R11: reset state
        n_vec++;
        if ({out_valid, out_we, out_undef, out_rd, out_result} !== 72'h0) begin
            n_fail++;
            $display("FAIL R11 actual=%h expected=0",
                     {out_valid, out_we, out_undef, out_rd, out_result});
        end
        in_valid = 1'b1; instr = mk(1, 6'd4, 5'd1, 5'd2);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 out_valid during reset actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;

        // R4..R8 with R3 at both widths, fixed and random operands
        foreach (ops[o]) begin
            for (int sf = 0; sf < 2; sf++) begin
                foreach (pats[p])
                    apply(1, mk(sf[0], ops[o], 5'($urandom), 5'($urandom)), pats[p], 1);
                for (int b = 0; b < 64; b += 7)
                    apply(1, mk(sf[0], ops[o], 5'($urandom), 5'($urandom)), 64'd1 << b, 1);
                for (int k = 0; k < 12; k++)
                    apply(1, mk(sf[0], ops[o], 5'($urandom), 5'($urandom)),
                          {$urandom, $urandom} >> ($urandom % 64), 1);
            end
        end

        // R9: extension ops with feature disabled, base ops still accepted
        foreach (ops[o])
            for (int sf = 0; sf < 2; sf++)
                apply(1, mk(sf[0], ops[o], 5'd3, 5'd9), {$urandom, $urandom}, 0);

        // R2: opcodes outside the set
        apply(1, mk(1, 6'd0, 5'd1, 5'd1), 64'h55, 1);
        apply(1, mk(0, 6'd3, 5'd1, 5'd1), 64'h55, 1);
        apply(1, mk(1, 6'd9, 5'd1, 5'd1), 64'h55, 1);
        apply(1, mk(0, 6'h3F, 5'd1, 5'd1), 64'h55, 1);

        // R1: fixed field mismatch
        apply(1, mk(1, 6'd4, 5'd1, 5'd4) ^ 32'h4000_0000, 64'h0, 1);
        apply(1, mk(0, 6'd7, 5'd1, 5'd4) ^ 32'h0001_0000, 64'hF, 1);
        apply(1, mk(1, 6'd8, 5'd1, 5'd4) ^ 32'h0020_0000, 64'hF, 1);

        // R10: idle cycles after activity, then resume
        apply(0, mk(1, 6'd7, 5'd1, 5'd5), 64'hFF, 1);
        apply(0, 32'hFFFF_FFFF, 64'hFFFF, 1);
        apply(1, mk(1, 6'd7, 5'd1, 5'd31), 64'hFF, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule